// File: doc/BRIEF.md
# Board Interrupt and Socket Status Controller

This block is a register-bus slave on a board-control chip. It gathers sixteen level-sensitive external interrupt inputs into one interrupt request for the processor. It also provides a small set of general registers for LED data, LED control, switches and miscellaneous control words. Software programs an enable mask. It reads a pending register, and it can overwrite that register directly to set or clear any pending bit. The interrupt request stays high while any bit is both pending and enabled.

Two of the interrupt inputs also serve as card-detect signals for two card sockets. Each socket has a status register. It shows an active-low card-present bit and a ready flag. Software can write only the five low bits of a socket status register, which hold the power and reset controls. The bus is synchronous and has no wait states. The read data is a combinational function of the address and the current register state, so a read never changes anything. There is no state machine. All behaviour is per-bit register logic.

Top module: `board_irq_ctrl`

## Requirements
- R1: Offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 are plain 32-bit read/write registers. Each resets to zero and reads back the last value written.
- R2: The enable mask (offset 0xC0) and the pending register (offset 0xD0) reset to zero. They keep only the bits set in 0x000FEEFF. Every other bit reads as zero, so inputs 8 and 12 can never become pending.
- R3: A write to offset 0xD0 replaces the whole pending register with the write data ANDed with 0x000FEEFF. The change is visible after the write edge, so one write can set some bits and clear others.
- R4: A pending bit is set only on a rising edge of its synchronized input while its enable bit is 1. An input whose enable bit is 0 does not latch. An input held high does not set its bit again after software clears it.
- R5: irq_out is high exactly when (pending AND mask) is nonzero. It follows a mask write or a pending write from the clock edge of that write.
- R6: Input 9 drives bit 5 of socket 0 status (offset 0xE0), and input 13 drives bit 5 of socket 1 status (offset 0xE4). The bit is 0 while the input is high and 1 while it is low. A change on the input shows after the second clock edge.
- R7: A write to a socket status register changes only bits [4:0]. Bits [31:5] keep their values.
- R8: After reset, both socket status registers read 0x00000420: bit 10 is ready and bit 5 is no card.
- R9: A read of an unmapped offset returns zero. A write to an unmapped offset changes no register.
- R10: If a pending-register write and an enabled rising edge of an input fall on the same clock edge, the pending bit for that input ends up set.
- R11: An enabled input that goes high is first visible in the pending register, and on irq_out, after the third clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_we | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for reg_addr, combinational |
| irq_in | input | N_IRQ (16) | External interrupt levels, asynchronous |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Register writes show on reg_rdata and irq_out from the write edge. A card-detect bit follows its input after two edges. A pending bit follows an input after three edges: two for the synchronizer and one for the latch. The bench drives inputs just after a rising edge and samples on the falling edge. A behavioural model, built on a three-stage history of the inputs, gives the expected value for every cycle. Directed checks read the pending register on the falling edge after the second rising edge and again after the third, which fixes the R11 latency exactly. The R10 test places its pending write on that third edge, so the write and the input edge land together.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;
    localparam int unsigned BC_DATA_W = 32;
    localparam int unsigned BC_ADDR_W = 8;
    localparam int unsigned BC_N_IRQ  = 16;

    localparam logic [31:0] BC_CTRL_WMASK = 32'h000F_EEFF;

    localparam logic [7:0] OFS_LED_A   = 8'h10;
    localparam logic [7:0] OFS_LED_B   = 8'h14;
    localparam logic [7:0] OFS_LED_CTL = 8'h40;
    localparam logic [7:0] OFS_SWITCH  = 8'h60;
    localparam logic [7:0] OFS_MISC_W1 = 8'h80;
    localparam logic [7:0] OFS_MISC_W2 = 8'h84;
    localparam logic [7:0] OFS_MISC_W3 = 8'h88;
    localparam logic [7:0] OFS_MISC_RD = 8'h90;
    localparam logic [7:0] OFS_IRQ_EN  = 8'hC0;
    localparam logic [7:0] OFS_IRQ_PND = 8'hD0;
    localparam logic [7:0] OFS_SOCK0   = 8'hE0;
    localparam logic [7:0] OFS_SOCK1   = 8'hE4;

    localparam int unsigned N_PLAIN = 8;
    localparam int unsigned N_SOCK  = 2;

    localparam int unsigned SOCK_WR_BITS = 5;
    localparam int unsigned SOCK_CD_BIT  = 5;
    localparam int unsigned SOCK_RDY_BIT = 10;

    function automatic logic [7:0] plain_ofs(input int unsigned idx);
        case (idx)
            0:       return OFS_LED_A;
            1:       return OFS_LED_B;
            2:       return OFS_LED_CTL;
            3:       return OFS_SWITCH;
            4:       return OFS_MISC_W1;
            5:       return OFS_MISC_W2;
            6:       return OFS_MISC_W3;
            default: return OFS_MISC_RD;
        endcase
    endfunction

    function automatic logic [7:0] sock_ofs(input int unsigned idx);
        return (idx == 0) ? OFS_SOCK0 : OFS_SOCK1;
    endfunction

    function automatic int unsigned sock_irq(input int unsigned idx);
        return (idx == 0) ? 9 : 13;
    endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out,
    output logic [N-1:0] rise_out
);
    logic [N-1:0] stage1_q;
    logic [N-1:0] stage2_q;
    logic [N-1:0] hist_q;

    for (genvar b = 0; b < N; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q[b] <= 1'b0;
                stage2_q[b] <= 1'b0;
                hist_q[b]   <= 1'b0;
            end else begin
                stage1_q[b] <= async_in[b];
                stage2_q[b] <= stage1_q[b];
                hist_q[b]   <= stage2_q[b];
            end
        end
        assign rise_out[b] = stage2_q[b] & ~hist_q[b];
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
    parameter int unsigned N      = 16,
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] WMASK = DATA_W'(32'h000F_EEFF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_reg,
    input  logic              wr_pnd_reg,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N-1:0]      rise,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] pnd_q,
    output logic              irq_out
);
    logic [DATA_W-1:0] rise_w;
    logic [DATA_W-1:0] pnd_base;
    logic [DATA_W-1:0] pnd_next;

    assign rise_w = DATA_W'(rise);

    always_comb begin
        pnd_base = wr_pnd_reg ? (wdata & WMASK) : pnd_q;
        pnd_next = pnd_base | (rise_w & en_q & WMASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            pnd_q <= '0;
        end else begin
            if (wr_en_reg) en_q <= wdata & WMASK;
            pnd_q <= pnd_next;
        end
    end

    assign irq_out = |(pnd_q & en_q);

    assert_pnd_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pnd_reg && (rise == '0)) |=> (pnd_q == ($past(wdata) & WMASK)));

    assert_no_unarmed_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pnd_reg) |=> ((pnd_q & ~$past(pnd_q) & ~$past(rise_w & en_q)) == '0));

    assert_set_beats_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pnd_reg |=> (($past(rise_w & en_q & WMASK) & ~pnd_q) == '0));
endmodule

// File: rtl/socket_status.sv
module socket_status #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned WR_BITS = 5,
    parameter int unsigned CD_BIT  = 5,
    parameter int unsigned RDY_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              card_in,
    output logic [DATA_W-1:0] status
);
    logic [WR_BITS-1:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ctl_q <= '0;
        else if (wr) ctl_q <= wdata[WR_BITS-1:0];
    end

    always_comb begin
        status                = '0;
        status[WR_BITS-1:0]   = ctl_q;
        status[CD_BIT]        = ~card_in;
        status[RDY_BIT]       = 1'b1;
    end

    assert_sock_upper_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && $stable(card_in)) |=> (status[DATA_W-1:WR_BITS] == $past(status[DATA_W-1:WR_BITS])));
endmodule

// File: rtl/plain_reg_bank.sv
module plain_reg_bank #(
    parameter int unsigned N_REGS = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_REGS-1:0]              wr_sel,
    input  logic [DATA_W-1:0]              wdata,
    output logic [N_REGS-1:0][DATA_W-1:0]  q
);
    for (genvar r = 0; r < N_REGS; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q[r] <= '0;
            else if (wr_sel[r]) q[r] <= wdata;
        end
    end

    assert_bank_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_sel));
endmodule

// File: rtl/board_irq_ctrl.sv
module board_irq_ctrl
    import board_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = BC_ADDR_W,
    parameter int unsigned DATA_W = BC_DATA_W,
    parameter int unsigned N_IRQ  = BC_N_IRQ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_IRQ-1:0]  irq_in,
    output logic              irq_out
);
    localparam logic [DATA_W-1:0] WMASK = DATA_W'(BC_CTRL_WMASK);

    logic [N_IRQ-1:0]                  sync_lvl;
    logic [N_IRQ-1:0]                  rise;
    logic [N_PLAIN-1:0]                plain_wr;
    logic [N_PLAIN-1:0][DATA_W-1:0]    plain_q;
    logic [N_SOCK-1:0]                 sock_wr;
    logic [N_SOCK-1:0][DATA_W-1:0]     sock_q;
    logic [DATA_W-1:0]                 en_q;
    logic [DATA_W-1:0]                 pnd_q;
    logic                              hit_en;
    logic                              hit_pnd;

    assign hit_en  = (reg_addr == ADDR_W'(OFS_IRQ_EN));
    assign hit_pnd = (reg_addr == ADDR_W'(OFS_IRQ_PND));

    for (genvar i = 0; i < N_PLAIN; i++) begin : g_pdec
        assign plain_wr[i] = reg_we && (reg_addr == ADDR_W'(plain_ofs(i)));
    end

    irq_sync_edge #(.N(N_IRQ)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (sync_lvl),
        .rise_out (rise)
    );

    irq_pend_ctrl #(.N(N_IRQ), .DATA_W(DATA_W), .WMASK(WMASK)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_reg  (reg_we && hit_en),
        .wr_pnd_reg (reg_we && hit_pnd),
        .wdata      (reg_wdata),
        .rise       (rise),
        .en_q       (en_q),
        .pnd_q      (pnd_q),
        .irq_out    (irq_out)
    );

    plain_reg_bank #(.N_REGS(N_PLAIN), .DATA_W(DATA_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (plain_wr),
        .wdata  (reg_wdata),
        .q      (plain_q)
    );

    for (genvar s = 0; s < N_SOCK; s++) begin : g_sock
        assign sock_wr[s] = reg_we && (reg_addr == ADDR_W'(sock_ofs(s)));
        socket_status #(
            .DATA_W  (DATA_W),
            .WR_BITS (SOCK_WR_BITS),
            .CD_BIT  (SOCK_CD_BIT),
            .RDY_BIT (SOCK_RDY_BIT)
        ) u_sock (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (sock_wr[s]),
            .wdata   (reg_wdata),
            .card_in (sync_lvl[sock_irq(s)]),
            .status  (sock_q[s])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N_PLAIN; i++) begin
            if (reg_addr == ADDR_W'(plain_ofs(i))) reg_rdata = plain_q[i];
        end
        for (int s = 0; s < N_SOCK; s++) begin
            if (reg_addr == ADDR_W'(sock_ofs(s))) reg_rdata = sock_q[s];
        end
        if (hit_en)  reg_rdata = en_q;
        if (hit_pnd) reg_rdata = pnd_q;
    end

    assert_irq_drops_on_zero_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && hit_en && ((reg_wdata & WMASK) == '0)) |=> !irq_out);

    assert_irq_rises_on_pend_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && hit_pnd && ((reg_wdata & en_q & WMASK) != '0) && !(reg_we && hit_en)) |=> irq_out);
endmodule

// File: tb/tb_board_irq_ctrl.sv
module tb_board_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [15:0] irq_in = 16'h0;
    logic        irq_out;

    int vectors = 0;
    int miscompares = 0;

    localparam logic [31:0] WM = 32'h000F_EEFF;

    always #5 clk = ~clk;

    board_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in), .irq_out(irq_out)
    );

    // behavioural reference model
    logic [31:0] m_store [256];
    logic [31:0] m_en, m_pnd;
    logic [4:0]  m_lo0, m_lo1;
    logic [15:0] m_h1, m_h2, m_h3;

    function automatic bit is_plain(input logic [7:0] a);
        return a inside {8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90};
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (is_plain(a)) return m_store[a];
        if (a == 8'hC0) return m_en;
        if (a == 8'hD0) return m_pnd;
        if (a == 8'hE0) return {21'h0, 1'b1, 4'h0, ~m_h2[9], m_lo0};
        if (a == 8'hE4) return {21'h0, 1'b1, 4'h0, ~m_h2[13], m_lo1};
        return 32'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) m_store[k] = 32'h0;
            m_en = 0; m_pnd = 0; m_lo0 = 0; m_lo1 = 0;
            m_h1 = 0; m_h2 = 0; m_h3 = 0;
        end else begin
            logic [31:0] risen, old_en, base;
            risen  = {16'h0, m_h2 & ~m_h3};
            old_en = m_en;
            base   = m_pnd;
            if (reg_we) begin
                if (is_plain(reg_addr)) m_store[reg_addr] = reg_wdata;
                if (reg_addr == 8'hC0) m_en = reg_wdata & WM;
                if (reg_addr == 8'hD0) base = reg_wdata & WM;
                if (reg_addr == 8'hE0) m_lo0 = reg_wdata[4:0];
                if (reg_addr == 8'hE4) m_lo1 = reg_wdata[4:0];
            end
            m_pnd = base | (risen & old_en & WM);
            m_h3 = m_h2; m_h2 = m_h1; m_h1 = irq_in;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 irq_out model", {31'h0, irq_out}, {31'h0, |(m_pnd & m_en)});
            chk("R1 reg_rdata model", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk); #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic set_in(input int idx, input logic v);
        @(posedge clk); #1;
        irq_in[idx] = v;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R8 / R2 reset state
        @(negedge clk); #1;
        chk("R5 irq_out after reset", {31'h0, irq_out}, 32'h0);
        rd_chk(8'hE0, 32'h0000_0420, "R8 socket0 reset");
        rd_chk(8'hE4, 32'h0000_0420, "R8 socket1 reset");
        rd_chk(8'hC0, 32'h0, "R2 mask reset");
        rd_chk(8'h10, 32'h0, "R1 plain reset");
        // R1 plain storage
        wr(8'h10, 32'hDEAD_BEEF);
        wr(8'h90, 32'h1234_5678);
        wr(8'h60, 32'hA5A5_0F0F);
        rd_chk(8'h10, 32'hDEAD_BEEF, "R1 led data A");
        rd_chk(8'h90, 32'h1234_5678, "R1 misc read reg");
        rd_chk(8'h60, 32'hA5A5_0F0F, "R1 switch reg");
        // R2 writable masks
        wr(8'hC0, 32'hFFFF_FFFF);
        rd_chk(8'hC0, 32'h000F_EEFF, "R2 mask bits");
        // R3 / R5 overwrite and interrupt
        wr(8'hD0, 32'hFFFF_FFFF);
        rd_chk(8'hD0, 32'h000F_EEFF, "R3 pend set all");
        chk("R5 irq high", {31'h0, irq_out}, 32'h1);
        wr(8'hD0, 32'h0000_0030);
        rd_chk(8'hD0, 32'h0000_0030, "R3 pend partial clear");
        wr(8'hC0, 32'h0);
        chk("R5 irq low mask zero", {31'h0, irq_out}, 32'h0);
        wr(8'hD0, 32'h0);
        // R11 latency
        wr(8'hC0, 32'h0000_0005);
        set_in(0, 1'b1);
        @(posedge clk); @(posedge clk); #1;
        reg_addr = 8'hD0;
        @(negedge clk); #1;
        chk("R11 pend not yet", reg_rdata, 32'h0);
        @(negedge clk); #1;
        chk("R11 pend after third edge", reg_rdata, 32'h1);
        chk("R11 irq after third edge", {31'h0, irq_out}, 32'h1);
        // R4 held-high input does not relatch
        wr(8'hD0, 32'h0);
        repeat (4) @(posedge clk);
        rd_chk(8'hD0, 32'h0, "R4 held high no relatch");
        // R4 masked input does not latch
        set_in(1, 1'b1);
        repeat (4) @(posedge clk);
        rd_chk(8'hD0, 32'h0, "R4 masked input ignored");
        // R2 input 8 cannot become pending
        wr(8'hC0, 32'hFFFF_FFFF);
        set_in(8, 1'b1);
        repeat (4) @(posedge clk);
        rd_chk(8'hD0, 32'h0, "R2 input 8 unlatchable");
        // R10 same-edge priority
        wr(8'hC0, 32'h0000_0004);
        set_in(2, 1'b1);
        @(posedge clk); @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = 8'hD0; reg_wdata = 32'h0;
        @(posedge clk); #1;
        reg_we = 1'b0;
        @(negedge clk); #1;
        chk("R10 set beats clear", reg_rdata, 32'h4);
        // R6 card detect
        set_in(9, 1'b1);
        @(posedge clk); #1;
        reg_addr = 8'hE0;
        @(negedge clk); #1;
        chk("R6 socket0 not yet", reg_rdata, 32'h420);
        @(negedge clk); #1;
        chk("R6 socket0 card present", reg_rdata, 32'h400);
        set_in(13, 1'b1);
        repeat (3) @(posedge clk);
        rd_chk(8'hE4, 32'h400, "R6 socket1 card present");
        // R7 partial writable
        wr(8'hE0, 32'hFFFF_FFFF);
        rd_chk(8'hE0, 32'h41F, "R7 socket0 low bits only");
        set_in(9, 1'b0);
        repeat (3) @(posedge clk);
        rd_chk(8'hE0, 32'h43F, "R6 socket0 card removed");
        // R9 unmapped
        rd_chk(8'h04, 32'h0, "R9 unmapped read");
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk(8'h10, 32'hDEAD_BEEF, "R9 unmapped write ignored");
        rd_chk(8'hC0, 32'h4, "R9 mask untouched");
        repeat (5) @(posedge clk);
        finish_run();
    end
endmodule